// File: doc/BRIEF.md
# Multi-master I2C random-read controller

This block is an I2C bus master that fetches one byte from a serial memory slave in a single, indivisible operation. A one-cycle start strobe supplies a 7-bit slave address and an 8-bit word address. The controller writes the word address into the slave's data pointer and turns the bus around with a repeated start. It then reads one byte back. Because the bus is held from the first start condition to the final stop, no other master can move the slave's pointer between the write phase and the read phase.

The bus pins are open-drain. The block only ever pulls SCL or SDA low and otherwise releases them. While it transmits, it compares each bit it releases with the level it reads back on SDA. If another master holds the line low, this controller has lost arbitration: it lets go of both lines on the next clock and reports the loss. The bit rate comes from a divider of the system clock. Each bit is split into four equal quarters: data is set up in the first, SCL is released in the second, SDA is sampled in the third and SCL is pulled low in the fourth.

Top module: `i2c_rr_master`

## Requirements
- R1: A successful transfer puts this exact sequence on the bus: start, slave address with bit0=0, slave ACK, word address, slave ACK, repeated start, slave address with bit0=1, slave ACK, one data byte from the slave, master NACK, stop. Exactly two start conditions and one stop condition appear, so no stop falls between the two phases. The read byte is presented on `rd_data` in the cycle `done` pulses.
- R2: Bytes are sent MSB first. Inside bit slots, SDA changes only while SCL is held low. Only start, repeated start and stop move SDA while SCL is high.
- R3: With nobody stretching the clock, consecutive SCL rising edges within a transfer are exactly 4*QDIV system clocks apart.
- R4: If an ACK slot after the slave address or after the word address is sampled high, the block generates a stop condition and then pulses `done` together with `nack_err`, with `arb_lost` low and `rd_data` left unchanged.
- R5: If the block releases SDA to send a 1 and samples SDA low while SCL is high, it releases SCL and SDA on the next clock. It pulses `done` and `arb_lost` for one cycle and generates no stop condition.
- R6: Arbitration loss is detected in any transmitted address bit, in the read/write bit of the second address byte, and in the word address bits.
- R7: When another master drives the same level as this block in every bit, the transfer completes normally with `arb_lost` low.
- R8: A start strobe during a transfer has no effect on that transfer.
- R9: A start strobe is ignored while the bus is busy, meaning a start condition has been seen on the bus and no stop has followed. Both lines stay released and no `done` is produced.
- R10: During and right after reset, both line drivers are released and `done`, `nack_err` and `arb_lost` are low.
- R11: After the eighth data bit, the master leaves SDA released during the ninth clock, which the slave sees as a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a random read |
| dev_addr | input | 7 | Slave address, sampled with `start` |
| word_addr | input | 8 | Memory word address, sampled with `start` |
| rd_data | output | 8 | Byte returned by the last successful read |
| done | output | 1 | One-cycle pulse when a transfer ends for any reason |
| nack_err | output | 1 | With `done`: the slave refused an ACK slot |
| arb_lost | output | 1 | With `done`: arbitration was lost to another master |
| scl_i | input | 1 | Level read back from the SCL line |
| sda_i | input | 1 | Level read back from the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that SCL is never held low by anyone else, since clock stretching is not handled. They also assume that SDA driven by a slave or a rival master settles well before the third quarter of a bit, and that `start` is a single-cycle pulse. The bench's slave and rival-master models change SDA only one system clock after they see SCL fall, and they never touch SCL. The bench raises `start` for exactly one clock. A rival master that wins keeps SDA low until the bench releases it, and that release produces the stop that frees the bus.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TX,
    ST_ACK,
    ST_RX,
    ST_MNACK,
    ST_STOP
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_SLA_W,
    PH_WADDR,
    PH_SLA_R,
    PH_RDATA
  } phase_t;

  // address byte on the wire: address in the upper bits, direction in bit 0
  function automatic logic [BYTE_W-1:0] addr_byte(input logic [ADDR_W-1:0] dev,
                                                  input logic rd);
    return {dev, rd};
  endfunction

  // system clocks between two SCL rising edges
  function automatic int unsigned scl_period(input int unsigned qdiv);
    return 4 * qdiv;
  endfunction

endpackage

// File: rtl/i2c_rr_qtick.sv
module i2c_rr_qtick #(
  parameter int QDIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // a quarter lasts QDIV clocks, so two ticks never touch (R3)
  p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/i2c_rr_busmon.sv
module i2c_rr_busmon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic bus_busy
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_s, scl_d, sda_d;
  logic start_seen, stop_seen;

  assign scl_s = scl_sh[SYNC-1];
  assign sda_s = sda_sh[SYNC-1];

  assign start_seen = scl_s && scl_d && sda_d && !sda_s;
  assign stop_seen  = scl_s && scl_d && !sda_d && sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      bus_busy <= 1'b0;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      if (start_seen) begin
        bus_busy <= 1'b1;
      end else if (stop_seen) begin
        bus_busy <= 1'b0;
      end
    end
  end

  p_busy_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> bus_busy);
  p_free_on_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !bus_busy);

endmodule

// File: rtl/i2c_rr_seq.sv
module i2c_rr_seq
  import i2c_rr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] word_addr,
  input  logic              bus_busy,
  input  logic              sda_s,
  output logic              run,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rd_data,
  output logic              done,
  output logic              nack_err,
  output logic              arb_lost
);
  seq_state_t        state;
  phase_t            phase;
  logic [1:0]        q;
  logic [BIT_CW-1:0] bitcnt;
  logic [BYTE_W-1:0] sh;
  logic [ADDR_W-1:0] dev_q;
  logic [BYTE_W-1:0] waddr_q;
  logic              ack_bad;
  logic              nack_flag;

  // named internal events
  logic accept, sample_pt, arb_evt, nack_evt, in_bit;

  assign run       = (state != ST_IDLE);
  assign accept    = start && (state == ST_IDLE) && !bus_busy;
  assign sample_pt = tick && (q == 2'd2);
  assign arb_evt   = sample_pt && (state == ST_TX) && sh[BYTE_W-1] && !sda_s;
  assign nack_evt  = sample_pt && (state == ST_ACK) && sda_s;
  assign in_bit    = (state == ST_TX) || (state == ST_ACK) ||
                     (state == ST_RX) || (state == ST_MNACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_SLA_W;
      q         <= 2'd0;
      bitcnt    <= '0;
      sh        <= '0;
      dev_q     <= '0;
      waddr_q   <= '0;
      ack_bad   <= 1'b0;
      nack_flag <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      rd_data   <= '0;
      done      <= 1'b0;
      nack_err  <= 1'b0;
      arb_lost  <= 1'b0;
    end else begin
      done     <= 1'b0;
      nack_err <= 1'b0;
      arb_lost <= 1'b0;
      if (accept) begin
        dev_q     <= dev_addr;
        waddr_q   <= word_addr;
        phase     <= PH_SLA_W;
        nack_flag <= 1'b0;
        q         <= 2'd0;
        state     <= ST_START;
      end else if (arb_evt) begin
        scl_oe   <= 1'b0;
        sda_oe   <= 1'b0;
        state    <= ST_IDLE;
        done     <= 1'b1;
        arb_lost <= 1'b1;
      end else if (tick && run) begin
        q <= q + 2'd1;
        case (state)
          ST_START: begin
            case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b1;
              default: begin
                scl_oe <= 1'b1;
                sh     <= addr_byte(dev_q, phase == PH_SLA_R);
                bitcnt <= BIT_CW'(BYTE_W - 1);
                state  <= ST_TX;
              end
            endcase
          end
          ST_TX: begin
            case (q)
              2'd0: sda_oe <= !sh[BYTE_W-1];
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin
                scl_oe <= 1'b1;
                if (bitcnt == '0) begin
                  state <= ST_ACK;
                end else begin
                  bitcnt <= bitcnt - 1'b1;
                  sh     <= {sh[BYTE_W-2:0], 1'b0};
                end
              end
            endcase
          end
          ST_ACK: begin
            case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: ack_bad <= nack_evt;
              default: begin
                scl_oe <= 1'b1;
                if (ack_bad) begin
                  nack_flag <= 1'b1;
                  state     <= ST_STOP;
                end else begin
                  case (phase)
                    PH_SLA_W: begin
                      phase  <= PH_WADDR;
                      sh     <= waddr_q;
                      bitcnt <= BIT_CW'(BYTE_W - 1);
                      state  <= ST_TX;
                    end
                    PH_WADDR: begin
                      phase <= PH_SLA_R;
                      state <= ST_START;
                    end
                    PH_SLA_R: begin
                      phase  <= PH_RDATA;
                      bitcnt <= BIT_CW'(BYTE_W - 1);
                      state  <= ST_RX;
                    end
                    default: state <= ST_STOP;
                  endcase
                end
              end
            endcase
          end
          ST_RX: begin
            case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: sh <= {sh[BYTE_W-2:0], sda_s};
              default: begin
                scl_oe <= 1'b1;
                if (bitcnt == '0) begin
                  state <= ST_MNACK;
                end else begin
                  bitcnt <= bitcnt - 1'b1;
                end
              end
            endcase
          end
          ST_MNACK: begin
            case (q)
              2'd0: sda_oe <= 1'b0;
              2'd1: scl_oe <= 1'b0;
              2'd2: ;
              default: begin
                scl_oe <= 1'b1;
                state  <= ST_STOP;
              end
            endcase
          end
          ST_STOP: begin
            case (q)
              2'd0: sda_oe <= 1'b1;
              2'd1: scl_oe <= 1'b0;
              2'd2: sda_oe <= 1'b0;
              default: begin
                state    <= ST_IDLE;
                done     <= 1'b1;
                nack_err <= nack_flag;
                if (!nack_flag) begin
                  rd_data <= sh;
                end
                nack_flag <= 1'b0;
              end
            endcase
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // SDA moves inside bit slots only while SCL is held low
  p_sda_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && $past(in_bit) && (sda_oe != $past(sda_oe))) |-> (scl_oe && $past(scl_oe)));

  p_arb_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_evt |=> (!scl_oe && !sda_oe && done && arb_lost));

  p_arb_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost);

  p_nack_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nack_err |-> (done && !arb_lost));

  p_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bus_busy && state == ST_IDLE) |=> (state == ST_IDLE));

  p_run_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE) |=> ($stable(dev_q) && $stable(waddr_q)));

endmodule

// File: rtl/i2c_rr_master.sv
module i2c_rr_master
  import i2c_rr_pkg::*;
#(
  parameter int QDIV = 8,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] word_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              done,
  output logic              nack_err,
  output logic              arb_lost,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic tick, run, sda_s, bus_busy;

  i2c_rr_qtick #(.QDIV(QDIV)) u_qtick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  i2c_rr_busmon #(.SYNC(SYNC)) u_busmon (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_s   (sda_s),
    .bus_busy(bus_busy)
  );

  i2c_rr_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start    (start),
    .dev_addr (dev_addr),
    .word_addr(word_addr),
    .bus_busy (bus_busy),
    .sda_s    (sda_s),
    .run      (run),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rd_data  (rd_data),
    .done     (done),
    .nack_err (nack_err),
    .arb_lost (arb_lost)
  );

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!scl_oe && !sda_oe && !done));

endmodule

// File: tb/i2c_rr_master_bench.sv
module i2c_rr_master_bench;
  localparam int QDIV = 6;
  localparam int GAP  = 4 * QDIV;
  localparam logic [6:0] SLV = 7'h50;
  localparam int NV = 6;
  // {dev[16:10], waddr[9:2], slave refuses word address[1], expect nack[0]}
  localparam logic [16:0] VEC [NV] = '{
    {7'h50, 8'h00, 1'b0, 1'b0},
    {7'h50, 8'hFF, 1'b0, 1'b0},
    {7'h50, 8'h3C, 1'b0, 1'b0},
    {7'h51, 8'h10, 1'b0, 1'b1},
    {7'h50, 8'h81, 1'b1, 1'b1},
    {7'h50, 8'h5A, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [7:0] word_addr = '0;
  logic [7:0] rd_data;
  logic done, nack_err, arb_lost, scl_oe, sda_oe;
  logic slv_pull = 1'b0, rival_pull = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slv_pull || rival_pull);

  always #5 clk = ~clk;

  i2c_rr_master #(.QDIV(QDIV)) u_i2c_rr_master (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
    .word_addr(word_addr), .rd_data(rd_data), .done(done),
    .nack_err(nack_err), .arb_lost(arb_lost), .scl_i(scl_line),
    .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] memfn(input logic [7:0] a);
    return (a * 8'd29) ^ 8'hC3;
  endfunction

  int checks = 0, errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor, slave memory model and rival master share one process
  logic nack_waddr = 1'b0, gap_clr = 1'b0;
  logic rv_arm = 1'b0;
  int rv_tstart = 0, rv_tbyte = 0, rv_tbit = 0;
  int n_start = 0, n_stop = 0, gmin = 0, gmax = 0, last_rise = 0;
  logic have_rise = 1'b0, s_mack = 1'b0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  logic s_act = 1'b0, s_tx = 1'b0, s_pend = 1'b0;
  int s_cnt = 9, s_byte = 0, rv_cnt = 9, rv_byte = 0, rv_starts = 0;
  logic [7:0] s_rx = '0, s_ptr = '0, s_dat = '0;

  always @(negedge clk) begin
    logic b_start, b_stop, b_fall, b_rise;
    cyc++;
    b_start = scl_line && scl_p && sda_p && !sda_line;
    b_stop  = scl_line && scl_p && !sda_p && sda_line;
    b_fall  = scl_p && !scl_line;
    b_rise  = !scl_p && scl_line;
    if (gap_clr) begin have_rise = 1'b0; gmin = 0; gmax = 0; end
    if (b_rise) begin
      if (have_rise) begin
        if (gmin == 0 || cyc - last_rise < gmin) gmin = cyc - last_rise;
        if (cyc - last_rise > gmax) gmax = cyc - last_rise;
      end
      have_rise = 1'b1;
      last_rise = cyc;
    end
    if (b_start) begin
      n_start++;
      s_act = 1'b1; s_cnt = 9; s_tx = 1'b0; s_pend = 1'b0; s_byte = 0; slv_pull = 1'b0;
      rv_starts++; rv_cnt = 9; rv_byte = 0;
    end else if (b_stop) begin
      n_stop++;
      s_act = 1'b0; s_tx = 1'b0; slv_pull = 1'b0; rv_starts = 0;
    end else begin
      if (b_rise && s_act) begin
        if (s_cnt < 8 && !s_tx) s_rx = {s_rx[6:0], sda_line};
        if (s_cnt == 8 && s_tx) begin
          s_mack = sda_line;
          if (sda_line) begin s_tx = 1'b0; s_act = 1'b0; end
        end
      end
      if (b_fall && s_act) begin
        s_cnt = (s_cnt >= 8) ? 0 : s_cnt + 1;
        if (s_cnt == 8) begin
          if (!s_tx) begin
            if (s_byte == 0) begin
              if (s_rx[7:1] == SLV) begin slv_pull = 1'b1; s_pend = s_rx[0]; end
              else begin slv_pull = 1'b0; s_act = 1'b0; end
            end else begin
              s_ptr = s_rx; slv_pull = !nack_waddr;
            end
            s_byte++;
          end else slv_pull = 1'b0;
        end else if (s_cnt == 0) begin
          if (s_pend && !s_tx) begin
            s_tx = 1'b1; s_pend = 1'b0; s_dat = memfn(s_ptr); slv_pull = !s_dat[7];
          end else slv_pull = 1'b0;
        end else if (s_tx) slv_pull = !s_dat[7-s_cnt];
      end
      if (b_fall) begin
        if (rv_cnt == 8) rv_byte++;
        rv_cnt = (rv_cnt >= 8) ? 0 : rv_cnt + 1;
        rival_pull = rv_arm && rv_starts == rv_tstart && rv_byte == rv_tbyte && rv_cnt == rv_tbit;
      end
    end
    if (!rv_arm) rival_pull = 1'b0;
    scl_p = scl_line;
    sda_p = sda_line;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  logic g_done, g_nack, g_arb;
  logic [7:0] g_data;

  task automatic pulse_start(input logic [6:0] d, input logic [7:0] w);
    @(posedge clk); #1;
    dev_addr = d; word_addr = w; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    g_done = 1'b0; g_nack = 1'b0; g_arb = 1'b0; g_data = '0;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); #1;
      if (done) begin
        g_done = 1'b1; g_nack = nack_err; g_arb = arb_lost; g_data = rd_data;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    int bs, bp;
    logic [7:0] prev_data;
    // R10: reset state
    idle(3);
    chk(!scl_oe && !sda_oe && !done && !nack_err && !arb_lost, "R10 in reset",
        {scl_oe, sda_oe, done, nack_err, arb_lost}, 0);
    rst_n = 1'b1;
    idle(3);
    chk(!scl_oe && !sda_oe && !done && !nack_err && !arb_lost, "R10 after reset",
        {scl_oe, sda_oe, done, nack_err, arb_lost}, 0);

    // table of vectors: R1, R2, R3, R4, R11
    for (int v = 0; v < NV; v++) begin
      nack_waddr = VEC[v][1];
      gap_clr = 1'b1; idle(2); gap_clr = 1'b0;
      s_mack = 1'b0;
      bs = n_start; bp = n_stop; prev_data = rd_data;
      pulse_start(VEC[v][16:10], VEC[v][9:2]);
      wait_done(20000);
      chk(g_done, "R1 done pulse", g_done, 1);
      chk(g_arb == 1'b0, "R7 no arbitration flag", g_arb, 0);
      chk(g_nack == VEC[v][0], "R4 nack flag", g_nack, VEC[v][0]);
      if (!VEC[v][0]) begin
        chk(g_data == memfn(VEC[v][9:2]), "R1 read data", g_data, memfn(VEC[v][9:2]));
        chk(n_start - bs == 2 && n_stop - bp == 1, "R1 R2 two starts one stop",
            (n_start - bs) * 16 + (n_stop - bp), 33);
        chk(s_mack == 1'b1, "R11 master nack on data byte", s_mack, 1);
        chk(gmin == GAP && gmax == GAP, "R3 scl period", gmax * 256 + gmin, GAP * 256 + GAP);
      end else begin
        chk(n_start - bs == 1 && n_stop - bp == 1, "R4 stop after refused ack",
            (n_start - bs) * 16 + (n_stop - bp), 17);
        chk(g_data == prev_data, "R4 rd_data unchanged", g_data, prev_data);
      end
      idle(40);
    end
    nack_waddr = 1'b0;

    // R5, R6: loss on a word-address bit (0xA5, third bit is 1)
    rv_tstart = 1; rv_tbyte = 1; rv_tbit = 2; rv_arm = 1'b1;
    bp = n_stop;
    pulse_start(SLV, 8'hA5);
    wait_done(20000);
    chk(g_done && g_arb && !g_nack, "R5 R6 arbitration lost in word address",
        {g_done, g_arb, g_nack}, 3'b110);
    chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
    chk(n_stop == bp, "R5 no stop generated", n_stop - bp, 0);
    idle(1);
    chk(!arb_lost && !done, "R5 flag lasts one cycle", {arb_lost, done}, 0);
    // R9: bus still held by the rival, a new request must be ignored
    idle(10);
    pulse_start(SLV, 8'h11);
    begin
      int seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(posedge clk); #1;
        if (done || scl_oe || sda_oe) seen++;
      end
      chk(seen == 0, "R9 start ignored while bus busy", seen, 0);
    end
    rv_arm = 1'b0;
    idle(60);

    // R7: rival drives the same 0 bit (0xA5, second bit is 0)
    rv_tstart = 1; rv_tbyte = 1; rv_tbit = 1; rv_arm = 1'b1;
    pulse_start(SLV, 8'hA5);
    wait_done(20000);
    chk(g_done && !g_arb && !g_nack, "R7 identical bit no contention",
        {g_done, g_arb, g_nack}, 3'b100);
    chk(g_data == memfn(8'hA5), "R7 data after identical bit", g_data, memfn(8'hA5));
    rv_arm = 1'b0;
    idle(60);

    // R6: loss on the direction bit of the second address byte
    rv_tstart = 2; rv_tbyte = 0; rv_tbit = 7; rv_arm = 1'b1;
    pulse_start(SLV, 8'h42);
    wait_done(20000);
    chk(g_done && g_arb, "R6 arbitration lost in read bit", {g_done, g_arb}, 2'b11);
    rv_arm = 1'b0;
    idle(60);

    // R6: loss on the first address bit (0x50 starts with 1)
    rv_tstart = 1; rv_tbyte = 0; rv_tbit = 0; rv_arm = 1'b1;
    pulse_start(SLV, 8'h42);
    wait_done(20000);
    chk(g_done && g_arb, "R6 arbitration lost in address bit", {g_done, g_arb}, 2'b11);
    chk(!scl_oe && !sda_oe, "R5 lines released after address loss", {scl_oe, sda_oe}, 0);
    rv_arm = 1'b0;
    idle(60);

    // R8: a second request in the middle of a transfer is ignored
    bs = n_start;
    pulse_start(SLV, 8'h6E);
    idle(300);
    pulse_start(7'h51, 8'h22);
    wait_done(20000);
    chk(g_done && !g_nack && !g_arb, "R8 transfer unaffected", {g_done, g_nack, g_arb}, 3'b100);
    chk(g_data == memfn(8'h6E), "R8 original data returned", g_data, memfn(8'h6E));
    chk(n_start - bs == 2, "R8 no extra start", n_start - bs, 2);
    idle(40);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule